// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

The sequencer produces the column addresses of one SDRAM read or write burst, one per clock. A start strobe captures a starting column, a burst-length code and a burst-order bit. From the next cycle on, the block presents one column per clock with a valid flag. For fixed-length bursts it also raises a flag on the final beat. Together these form a column stream that a command engine can put on the address pins beat by beat.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned group of columns that holds the starting column, and the group size equals the burst length. The bits above the group field do not change during the burst. The bits below it step in either linear (wrapping) order or XOR order. A full-page burst walks the whole 512-column row in linear order and wraps from the top column to column 0. It runs until it is terminated or replaced by a new start.

Top module: `sdram_col_seq`

## Requirements
- R1: While reset is asserted and after reset, `valid_o` and `last_o` are 0 until a start is seen.
- R2: A start at a clock edge makes `valid_o` high from the next cycle, and that first beat's column equals the captured `start_col_i`.
- R3: Burst-length code `bl_i` is 0 for 2 beats, 1 for 4 beats, 2 for 8 beats and 3 for full page. A fixed burst gives exactly that many valid beats, `last_o` is high on the final one only, and `valid_o` drops the cycle after.
- R4: During a 2-, 4- or 8-beat burst, the column bits above log2(length) keep the starting column's value.
- R5: With `ilv_i`=0, beat k of a fixed burst has low field equal to (start low field + k) modulo the length.
- R6: With `ilv_i`=1, beat k of a fixed burst has low field equal to start low field XOR k.
- R7: In full-page mode, beat k is (start + k) modulo 512 whatever `ilv_i` is, and `last_o` is never raised.
- R8: `term_i` during a burst ends it, so `valid_o` is low the next cycle. `term_i` while idle has no effect.
- R9: A start during a burst, including on its last beat, abandons that burst and begins the new one on the next cycle.
- R10: Length and order are captured at the start. Changes to `bl_i` and `ilv_i` during a burst have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new burst |
| start_col_i | input | 9 | Starting column, sampled with start_i |
| bl_i | input | 2 | Burst-length code, sampled with start_i |
| ilv_i | input | 1 | 0 linear order, 1 XOR order, sampled with start_i |
| term_i | input | 1 | End the current burst |
| col_o | output | 9 | Column of the current beat |
| valid_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The hardest case to reach from the ports is the start strobe that lands in the same cycle as the final beat, or in the middle of a burst. Here the old burst must give way without losing a cycle, and the new mode must take over at once. The bench drives restarts at chosen beat indices, including the last one. It also sweeps every start column under every fixed length and both orders, and it flips the length and order inputs during each burst. A full-page burst is started a few columns below 511 so that it crosses the wrap to column 0.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
  typedef enum logic [1:0] {
    BL_2    = 2'd0,
    BL_4    = 2'd1,
    BL_8    = 2'd2,
    BL_PAGE = 2'd3
  } burst_len_e;

  typedef struct packed {
    burst_len_e len;
    logic       ilv;
  } burst_mode_t;
endpackage

// File: rtl/sdram_col_ctl.sv
module sdram_col_ctl
  import sdram_col_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       bl_i,
  input  logic             ilv_i,
  input  logic             term_i,
  output logic             active_o,
  output logic             last_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] base_o,
  output burst_mode_t      mode_o
);
  logic             active_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] base_q;
  burst_mode_t      mode_q;
  logic [COL_W-1:0] final_beat;

  always_comb begin
    unique case (mode_q.len)
      BL_2:    final_beat = COL_W'(1);
      BL_4:    final_beat = COL_W'(3);
      BL_8:    final_beat = COL_W'(7);
      default: final_beat = '1;
    endcase
  end

  // full page never flags its own end
  assign last_o = active_q && (mode_q.len != BL_PAGE) && (beat_q == final_beat);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      mode_q   <= '{len: BL_2, ilv: 1'b0};
    end else if (start_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      base_q   <= start_col_i;
      mode_q   <= '{len: burst_len_e'(bl_i), ilv: ilv_i};
    end else if (active_q) begin
      if (last_o || term_i) begin
        active_q <= 1'b0;
      end else begin
        beat_q <= beat_q + COL_W'(1);
      end
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign base_o   = base_q;
  assign mode_o   = mode_q;

  p_last_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !active_q);
  p_term_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && term_i && !start_i |=> !active_q);
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q && !start_i |=> !active_q);
  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> active_q && beat_q == '0);
  p_mode_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !start_i |=> $stable(mode_q) && $stable(base_q));
endmodule

// File: rtl/sdram_col_map.sv
module sdram_col_map
  import sdram_col_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  burst_mode_t      mode_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] lin_sum;
  logic [COL_W-1:0] xor_idx;
  logic [COL_W-1:0] blk_mask;
  logic             page;

  assign lin_sum = base_i + beat_i;
  assign xor_idx = base_i ^ beat_i;
  assign page    = (mode_i.len == BL_PAGE);

  always_comb begin
    unique case (mode_i.len)
      BL_2:    blk_mask = COL_W'(1);
      BL_4:    blk_mask = COL_W'(3);
      BL_8:    blk_mask = COL_W'(7);
      default: blk_mask = '0;
    endcase
  end

  // per bit: page walk, in-block step, or frozen block field
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col_o[i] = page        ? lin_sum[i] :
                      blk_mask[i] ? (mode_i.ilv ? xor_idx[i] : lin_sum[i]) :
                                    base_i[i];
  end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import sdram_col_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       bl_i,
  input  logic             ilv_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] base;
  burst_mode_t      mode;

  sdram_col_ctl #(.COL_W(COL_W)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .bl_i        (bl_i),
    .ilv_i       (ilv_i),
    .term_i      (term_i),
    .active_o    (valid_o),
    .last_o      (last_o),
    .beat_o      (beat),
    .base_o      (base),
    .mode_o      (mode)
  );

  sdram_col_map #(.COL_W(COL_W)) u_map (
    .base_i (base),
    .beat_i (beat),
    .mode_i (mode),
    .col_o  (col_o)
  );

  p_first_col_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && col_o == $past(start_col_i));
  p_last_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
  p_block_fixed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o && !start_i && !term_i && mode.len != BL_PAGE
    |=> $stable(col_o[COL_W-1:3]));
  p_page_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && mode.len == BL_PAGE && !start_i && !term_i
    |=> valid_o && col_o == $past(col_o) + COL_W'(1));
  p_page_nolast_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && mode.len == BL_PAGE |-> !last_o);
endmodule

// File: tb/tb_sdram_col_seq.sv
module tb_sdram_col_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [8:0] col_in = '0;
  logic [1:0] bl_in = '0;
  logic       ilv_in = 1'b0;
  logic       term = 1'b0;
  logic [8:0] col;
  logic       valid;
  logic       last;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sdram_col_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_col_i(col_in),
    .bl_i(bl_in), .ilv_i(ilv_in), .term_i(term),
    .col_o(col), .valid_o(valid), .last_o(last)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(int bl, bit ilv, int s, int k);
    int n = 2 << bl;
    if (bl == 3) return (s + k) % 512;
    if (ilv) return (s / n) * n + ((s % n) ^ k);
    return (s / n) * n + ((s % n) + k) % n;
  endfunction

  task automatic do_start(int bl, bit ilv, int s);
    @(negedge clk);
    start = 1'b1; col_in = 9'(s); bl_in = 2'(bl); ilv_in = ilv;
    @(negedge clk);
    start = 1'b0; bl_in = 2'(3 - bl); ilv_in = !ilv; col_in = 9'(511 - s);  // R10 disturbance
  endtask

  task automatic check_beat(int bl, bit ilv, int s, int k, bit want_last);
    string rq;
    int n = 2 << bl;
    rq = (bl == 3) ? "R7" : (ilv ? "R6" : "R5");
    chk(valid == 1'b1, "R2 valid", int'(valid), 1);
    chk(int'(col) == exp_col(bl, ilv, s, k), rq, int'(col), exp_col(bl, ilv, s, k));
    chk(last == want_last, "R3 last", int'(last), int'(want_last));
    if (bl != 3)
      chk(int'(col) / n == s / n, "R4 block", int'(col) / n, s / n);
  endtask

  task automatic full_burst(int bl, bit ilv, int s);
    int n = 2 << bl;
    do_start(bl, ilv, s);
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      check_beat(bl, ilv, s, k, k == n - 1);
    end
    @(negedge clk);
    chk(valid == 1'b0, "R3 end", int'(valid), 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(valid == 1'b0, "R1 valid in reset", int'(valid), 0);
    chk(last == 1'b0, "R1 last in reset", int'(last), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid == 1'b0, "R1 valid after reset", int'(valid), 0);

    // R5 R6 R4 R3 R10: every start column, every fixed length, both orders
    for (int bl = 0; bl < 3; bl++)
      for (int il = 0; il < 2; il++)
        for (int s = 0; s < 512; s++)
          full_burst(bl, il[0], s);

    // R7: full page across the wrap, XOR order requested but ignored
    do_start(3, 1'b1, 505);
    for (int k = 0; k < 12; k++) begin
      if (k > 0) @(negedge clk);
      check_beat(3, 1'b1, 505, k, 1'b0);
    end
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    chk(valid == 1'b0, "R8 term page", int'(valid), 0);

    // R8: terminate mid BL8
    do_start(2, 1'b0, 44);
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      check_beat(2, 1'b0, 44, k, 1'b0);
    end
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    chk(valid == 1'b0, "R8 term mid", int'(valid), 0);

    // R8: terminate while idle has no effect, next burst is normal
    term = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(valid == 1'b0, "R8 idle term", int'(valid), 0);
    end
    term = 1'b0;
    full_burst(1, 1'b1, 6);

    // R9: restart mid burst with a different mode
    do_start(2, 1'b0, 10);
    @(negedge clk);
    check_beat(2, 1'b0, 10, 1, 1'b0);
    start = 1'b1; col_in = 9'd101; bl_in = 2'd1; ilv_in = 1'b1;
    @(negedge clk);
    start = 1'b0; bl_in = 2'd3; ilv_in = 1'b0;
    chk(int'(col) == 100 + (1 ^ 0), "R9 restart col", int'(col), 101);
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      check_beat(1, 1'b1, 101, k, k == 3);
    end
    @(negedge clk);
    chk(valid == 1'b0, "R9 restart end", int'(valid), 0);

    // R9: restart on the final beat
    do_start(0, 1'b0, 2);
    @(negedge clk);
    check_beat(0, 1'b0, 2, 1, 1'b1);
    start = 1'b1; col_in = 9'd7; bl_in = 2'd0; ilv_in = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(valid == 1'b1, "R9 restart on last", int'(valid), 1);
    check_beat(0, 1'b0, 7, 0, 1'b0);
    @(negedge clk);
    check_beat(0, 1'b0, 7, 1, 1'b1);
    @(negedge clk);
    chk(valid == 1'b0, "R9 end after last", int'(valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule